// File: doc/BRIEF.md
# Interrupt Map and Clear Controller

This block sits between interrupt request sources and the interrupt vector lines of a host bridge. It accepts 32 level requests from PCI slots (eight groups of four pins) and 16 level requests from on-board devices. Each request drives one of 48 level vector outputs. A map register gates each output: the 32 PCI requests share 8 map registers, four pins to a register, and each on-board request has a map register of its own. A vector line follows its request only while the enable bit of its map is set.

Software reaches the block through a 32-bit register port with byte offsets. Each map register sits in the upper word of an 8-byte slot. Only its enable bit (bit 31) can be written. The low 31 bits hold a fixed routing code that reads back as set at power-up. Separate clear registers force a pending vector line low. The line then stays low until its request has been seen low. This lets the handler drop a line whose device has not yet withdrawn its request. Any reset clears every enable bit and keeps the routing codes.

Each vector line is driven by its own three-state machine:
- **LN_IDLE** (output low). It moves to LN_ACTIVE when the line's map is enabled and the registered request is high. It moves to LN_CLEARED on a clear.
- **LN_ACTIVE** (output high). It moves to LN_CLEARED on a clear. It moves to LN_IDLE when the map is disabled or the request falls.
- **LN_CLEARED** (output low). It moves to LN_IDLE once the registered request is low and no clear is present.

A clear write has priority in every state.

Top module: `irq_route_ctl`

## Requirements
- R1: While rst_ni is low, and after any reset, every vector output is low and every map enable bit is 0. A reset leaves the routing code in bits 30:0 unchanged.
- R2: Reads return map contents at these offsets:
  - PCI map i (i = 0..7) at offset 0x0C04 + 8*i reads {enable, 31'(0x7C0 | (i << 2))}.
  - On-board map k (k = 0..15) at offset 0x1004 + 8*k reads {enable, 31'(0x7E0 + k)}.
- R3: A write to a map register changes only bit 31. The routing code in bits 30:0 never changes. The lower word of each slot (offset bit 2 = 0) reads as zero and ignores writes.
- R4: Requests are registered once, and each output is registered after its gate. A request input sampled at clock edge k reaches ivec_o after edge k+1.
  - PCI request n (pci_req_i[n]) drives ivec_o[n] under PCI map n/4.
  - On-board request k drives ivec_o[32+k] under on-board map k.
  - A line with its map disabled stays low.
- R5: A write to PCI clear slot j (offset 0x1404 + 8*j, j = 0..7) drops ivec_o[j]. A write to on-board clear slot j (offset 0x1804 + 8*j, j = 0..11) drops ivec_o[32+j]. Either way the line is low after the write's clock edge. It stays low, with no effect on other lines, until the registered request has been low for one edge.
- R6: A clear in the same cycle as an asserted registered request wins: the line does not go high.
- R7: Offsets outside the map windows read zero, and writes to them have no effect. This covers on-board clear slots above 11 (offset 0x1864 and up).
- R8: rdata_o is registered. It takes the addressed value one edge after a cycle with rd_en_i high and holds otherwise. A read and a write in the same cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 16 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pci_req_i | input | 32 | PCI slot request levels, four pins per slot group |
| ob_req_i | input | 16 | On-board source request levels |
| ivec_o | output | 48 | Interrupt vector line levels |

## Verification
The assertions take the request inputs and the register strobes to be synchronous to clk_i, so a registered request or decoded clear is stable across each edge. They also assume that rst_ni, although asynchronous, is released away from an edge. The stimulus changes every input only at the falling clock edge. It toggles requests sparsely, so a held request meets enable changes and clears. Its offsets mix valid map and clear slots with lower words, clear slots beyond the last on-board one, and random unmapped offsets.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int ADDR_W = 16;

    // Register windows (byte offsets, inclusive).
    localparam logic [ADDR_W-1:0] PCI_MAP_LO = 16'h0C00;
    localparam logic [ADDR_W-1:0] PCI_MAP_HI = 16'h0C3F;
    localparam logic [ADDR_W-1:0] OB_MAP_LO  = 16'h1000;
    localparam logic [ADDR_W-1:0] OB_MAP_HI  = 16'h1080;
    localparam logic [ADDR_W-1:0] PCI_CLR_LO = 16'h1400;
    localparam logic [ADDR_W-1:0] PCI_CLR_HI = 16'h143F;
    localparam logic [ADDR_W-1:0] OB_CLR_LO  = 16'h1800;
    localparam logic [ADDR_W-1:0] OB_CLR_HI  = 16'h1860;

    localparam int SLOT_SHIFT = 3;
    localparam int ROUTE_W    = 31;

    typedef enum logic [1:0] {
        LN_IDLE    = 2'd0,
        LN_ACTIVE  = 2'd1,
        LN_CLEARED = 2'd2
    } line_state_e;

    // An offset hits a window when it is inside it, on the upper word of
    // an 8-byte slot, and its slot number is below the slot count.
    function automatic logic in_window(
        input logic [ADDR_W-1:0] a,
        input logic [ADDR_W-1:0] lo,
        input logic [ADDR_W-1:0] hi,
        input int unsigned       slots
    );
        logic [ADDR_W-1:0] diff;
        diff = a - lo;
        return (a >= lo) && (a <= hi) && a[2] &&
               (int'(diff >> SLOT_SHIFT) < int'(slots));
    endfunction

    function automatic logic [ADDR_W-1:0] slot_of(
        input logic [ADDR_W-1:0] a,
        input logic [ADDR_W-1:0] lo
    );
        return (a - lo) >> SLOT_SHIFT;
    endfunction

    function automatic logic [ROUTE_W-1:0] pci_route(input int i);
        return ROUTE_W'(32'h7C0 | (32'(i) << 2));
    endfunction

    function automatic logic [ROUTE_W-1:0] ob_route(input int k);
        return ROUTE_W'(32'h7E0 + 32'(k));
    endfunction

endpackage

// File: rtl/irq_map_bank.sv
module irq_map_bank
    import irq_route_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int PCI_MAPS = 8,
    parameter int OB_MAPS  = 16,
    localparam int PIDX_W  = (PCI_MAPS > 1) ? $clog2(PCI_MAPS) : 1,
    localparam int OIDX_W  = (OB_MAPS > 1) ? $clog2(OB_MAPS) : 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic                rd_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                en_bit_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic [PCI_MAPS-1:0] pci_en_o,
    output logic [OB_MAPS-1:0]  ob_en_o
);

    logic              pci_hit, ob_hit;
    logic [PIDX_W-1:0] pci_idx;
    logic [OIDX_W-1:0] ob_idx;
    logic [PCI_MAPS-1:0] pci_en_q;
    logic [OB_MAPS-1:0]  ob_en_q;
    logic [DATA_W-1:0]   rd_val;
    logic [DATA_W-1:0]   rdata_q;

    always_comb begin
        pci_hit = in_window(addr_i, PCI_MAP_LO, PCI_MAP_HI, PCI_MAPS);
        ob_hit  = in_window(addr_i, OB_MAP_LO, OB_MAP_HI, OB_MAPS);
        pci_idx = PIDX_W'(slot_of(addr_i, PCI_MAP_LO));
        ob_idx  = OIDX_W'(slot_of(addr_i, OB_MAP_LO));
    end

    // Only the enable bits are storage; routing codes are fixed.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pci_en_q <= '0;
            ob_en_q  <= '0;
        end else if (wr_en_i) begin
            if (pci_hit) begin
                pci_en_q[pci_idx] <= en_bit_i;
            end
            if (ob_hit) begin
                ob_en_q[ob_idx] <= en_bit_i;
            end
        end
    end

    always_comb begin
        rd_val = '0;
        if (pci_hit) begin
            rd_val = DATA_W'({pci_en_q[pci_idx], pci_route(int'(pci_idx))});
        end else if (ob_hit) begin
            rd_val = DATA_W'({ob_en_q[ob_idx], ob_route(int'(ob_idx))});
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rdata_q <= '0;
        end else if (rd_en_i) begin
            rdata_q <= rd_val;
        end
    end

    assign rdata_o  = rdata_q;
    assign pci_en_o = pci_en_q;
    assign ob_en_o  = ob_en_q;

endmodule

// File: rtl/irq_clear_dec.sv
module irq_clear_dec
    import irq_route_pkg::*;
#(
    parameter int PCI_LINES    = 32,
    parameter int PCI_CLR_SLOTS = 8,
    parameter int OB_CLR_SLOTS = 12,
    parameter int LINES        = 48
) (
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [LINES-1:0]  clr_o
);

    logic pci_hit, ob_hit;
    int   pci_line, ob_line;

    always_comb begin
        pci_hit  = in_window(addr_i, PCI_CLR_LO, PCI_CLR_HI, PCI_CLR_SLOTS);
        ob_hit   = in_window(addr_i, OB_CLR_LO, OB_CLR_HI, OB_CLR_SLOTS);
        pci_line = int'(slot_of(addr_i, PCI_CLR_LO));
        ob_line  = PCI_LINES + int'(slot_of(addr_i, OB_CLR_LO));
        clr_o    = '0;
        if (wr_en_i && pci_hit && (pci_line < LINES)) begin
            clr_o[pci_line] = 1'b1;
        end
        if (wr_en_i && ob_hit && (ob_line < LINES)) begin
            clr_o[ob_line] = 1'b1;
        end
    end

endmodule

// File: rtl/irq_line_gate.sv
module irq_line_gate
    import irq_route_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    input  logic en_i,
    input  logic clr_i,
    output logic irq_o
);

    line_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= LN_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_IDLE: begin
                if (clr_i) begin
                    state_d = LN_CLEARED;
                end else if (en_i && req_i) begin
                    state_d = LN_ACTIVE;
                end
            end
            LN_ACTIVE: begin
                if (clr_i) begin
                    state_d = LN_CLEARED;
                end else if (!en_i || !req_i) begin
                    state_d = LN_IDLE;
                end
            end
            LN_CLEARED: begin
                if (!clr_i && !req_i) begin
                    state_d = LN_IDLE;
                end
            end
            default: state_d = LN_IDLE;
        endcase
    end

    always_comb begin
        irq_o = (state_q == LN_ACTIVE);
    end

endmodule

// File: rtl/irq_route_ctl.sv
module irq_route_ctl
    import irq_route_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int PINS_PER_MAP = 4,
    parameter int PCI_MAPS     = 8,
    parameter int OB_LINES     = 16,
    parameter int PCI_CLR_SLOTS = 8,
    parameter int OB_CLR_SLOTS = 12,
    localparam int PCI_LINES   = PCI_MAPS * PINS_PER_MAP,
    localparam int LINES       = PCI_LINES + OB_LINES
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_en_i,
    input  logic                 rd_en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    rdata_o,
    input  logic [PCI_LINES-1:0] pci_req_i,
    input  logic [OB_LINES-1:0]  ob_req_i,
    output logic [LINES-1:0]     ivec_o
);

    logic [PCI_MAPS-1:0] pci_en;
    logic [OB_LINES-1:0] ob_en;
    logic [LINES-1:0]    req_q;
    logic [LINES-1:0]    line_en;
    logic [LINES-1:0]    clr_hit;
    logic                unused_wdata;

    assign unused_wdata = ^wdata_i[DATA_W-2:0];

    irq_map_bank #(
        .DATA_W   (DATA_W),
        .PCI_MAPS (PCI_MAPS),
        .OB_MAPS  (OB_LINES)
    ) u_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wr_en_i),
        .rd_en_i  (rd_en_i),
        .addr_i   (addr_i),
        .en_bit_i (wdata_i[DATA_W-1]),
        .rdata_o  (rdata_o),
        .pci_en_o (pci_en),
        .ob_en_o  (ob_en)
    );

    irq_clear_dec #(
        .PCI_LINES     (PCI_LINES),
        .PCI_CLR_SLOTS (PCI_CLR_SLOTS),
        .OB_CLR_SLOTS  (OB_CLR_SLOTS),
        .LINES         (LINES)
    ) u_clr (
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .clr_o   (clr_hit)
    );

    // One register stage on every request before gating.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            req_q <= '0;
        end else begin
            req_q <= {ob_req_i, pci_req_i};
        end
    end

    for (genvar n = 0; n < LINES; n++) begin : g_line
        if (n < PCI_LINES) begin : g_pci
            assign line_en[n] = pci_en[n / PINS_PER_MAP];
        end else begin : g_ob
            assign line_en[n] = ob_en[n - PCI_LINES];
        end

        irq_line_gate u_gate (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .req_i  (req_q[n]),
            .en_i   (line_en[n]),
            .clr_i  (clr_hit[n]),
            .irq_o  (ivec_o[n])
        );
    end

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
    parameter int DATA_W = 32,
    parameter int LINES  = 48
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              rd_en_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic [LINES-1:0]  ivec_o,
    input logic [LINES-1:0]  req_q,
    input logic [LINES-1:0]  line_en,
    input logic [LINES-1:0]  clr_hit
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (ivec_o == '0));

    // R4
    gate_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ivec_o & ~$past(line_en)) == '0);

    // R4
    gate_request_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ivec_o & ~$past(req_q)) == '0);

    // R5
    clear_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ivec_o & $past(clr_hit)) == '0);

    // R8
    rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rdata_o));

endmodule

bind irq_route_ctl irq_route_chk #(
    .DATA_W (DATA_W),
    .LINES  (LINES)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (rd_en_i),
    .rdata_o (rdata_o),
    .ivec_o  (ivec_o),
    .req_q   (req_q),
    .line_en (line_en),
    .clr_hit (clr_hit)
);

// File: tb/irq_route_ctl_tb_top.sv
`timescale 1ns/1ps
module irq_route_ctl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata_o;
    logic [31:0] pci_req = '0;
    logic [15:0] ob_req = '0;
    logic [47:0] ivec_o;

    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    irq_route_ctl dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .rd_en_i   (rd_en),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .rdata_o   (rdata_o),
        .pci_req_i (pci_req),
        .ob_req_i  (ob_req),
        .ivec_o    (ivec_o)
    );

    // ---------------- expected-value model from the requirements -------------
    logic [7:0]  m_pen;
    logic [15:0] m_oen;
    logic [47:0] m_req, m_ivec, m_blk;
    logic [31:0] m_rdata;

    function automatic bit m_win(logic [15:0] a, int lo, int hi);
        return (int'(a) >= lo) && (int'(a) <= hi) && a[2];
    endfunction

    function automatic int m_idx(logic [15:0] a, int lo);
        return (int'(a) - lo) >> 3;
    endfunction

    function automatic logic [31:0] m_read(logic [15:0] a);
        if (m_win(a, 'h0C00, 'h0C3F))
            return {m_pen[m_idx(a, 'h0C00)], 31'(32'h7C0 | (32'(m_idx(a, 'h0C00)) << 2))};
        if (m_win(a, 'h1000, 'h1080) && m_idx(a, 'h1000) < 16)
            return {m_oen[m_idx(a, 'h1000)], 31'(32'h7E0 + 32'(m_idx(a, 'h1000)))};
        return 32'h0;
    endfunction

    function automatic bit m_clr(int n);
        if (!wr_en) return 1'b0;
        if (m_win(addr, 'h1400, 'h143F) && m_idx(addr, 'h1400) == n) return 1'b1;
        if (m_win(addr, 'h1800, 'h1860) && m_idx(addr, 'h1800) < 12 &&
            32 + m_idx(addr, 'h1800) == n) return 1'b1;
        return 1'b0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pen <= '0; m_oen <= '0; m_req <= '0;
            m_ivec <= '0; m_blk <= '0; m_rdata <= '0;
        end else begin
            m_req <= {ob_req, pci_req};
            for (int n = 0; n < 48; n++) begin
                bit c, e;
                c = m_clr(n);
                e = (n < 32) ? m_pen[n / 4] : m_oen[n - 32];
                m_ivec[n] <= e & m_req[n] & ~c & ~m_blk[n];
                m_blk[n]  <= c | (m_blk[n] & m_req[n]);
            end
            if (rd_en) m_rdata <= m_read(addr);
            if (wr_en && m_win(addr, 'h0C00, 'h0C3F))
                m_pen[m_idx(addr, 'h0C00)] <= wdata[31];
            if (wr_en && m_win(addr, 'h1000, 'h1080) && m_idx(addr, 'h1000) < 16)
                m_oen[m_idx(addr, 'h1000)] <= wdata[31];
        end
    end

    // ---------------- helpers -------------------------------------------------
    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic bus_write(logic [15:0] a, logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(logic [15:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
        d = rdata_o;
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [31:0] held;
        void'($urandom(32'd1207));
        repeat (3) @(negedge clk);
        check("R1 ivec in reset", 64'(ivec_o), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset contents
        bus_read(16'h0C1C, r); check("R2 pci map3", 64'(r), 64'h0000_07CC);
        bus_read(16'h102C, r); check("R2 ob map5", 64'(r), 64'h0000_07E5);

        // R3 only bit 31 writes; lower words dead
        bus_write(16'h0C1C, 32'hFFFF_0000);
        bus_read(16'h0C1C, r); check("R3 enable only", 64'(r), 64'h8000_07CC);
        bus_write(16'h0C18, 32'h0000_0000);
        bus_read(16'h0C1C, r); check("R3 lower write ignored", 64'(r), 64'h8000_07CC);
        bus_read(16'h0C18, r); check("R3 lower read zero", 64'(r), 64'h0);

        // R4 gating
        pci_req[13] = 1'b1; pci_req[5] = 1'b1;
        settle();
        check("R4 enabled line 13", 64'(ivec_o[13]), 64'h1);
        check("R4 disabled line 5", 64'(ivec_o[5]), 64'h0);
        bus_write(16'h0C1C, 32'h0);
        settle();
        check("R4 disable drops 13", 64'(ivec_o[13]), 64'h0);

        // R5 PCI clear slot 7 drops line 7
        bus_write(16'h0C0C, 32'h8000_0000);
        pci_req[7] = 1'b1;
        settle();
        check("R5 line 7 up", 64'(ivec_o[7]), 64'h1);
        bus_write(16'h143C, 32'h0);
        check("R5 line 7 cleared", 64'(ivec_o[7]), 64'h0);
        check("R5 line 5 untouched", 64'(ivec_o[5]), 64'h1);
        repeat (3) @(negedge clk);
        check("R5 held low", 64'(ivec_o[7]), 64'h0);
        pci_req[7] = 1'b0; settle();
        pci_req[7] = 1'b1; settle();
        check("R5 rearmed", 64'(ivec_o[7]), 64'h1);

        // R6 clear meets a fresh request
        pci_req[7] = 1'b0; settle();
        pci_req[7] = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_write(16'h143C, 32'h0);
        check("R6 clear wins", 64'(ivec_o[7]), 64'h0);

        // R5 on-board clear
        bus_write(16'h1014, 32'h8000_0000);
        ob_req[2] = 1'b1; settle();
        check("R4 ob line 34", 64'(ivec_o[34]), 64'h1);
        bus_write(16'h1814, 32'h0);
        check("R5 ob line 34 cleared", 64'(ivec_o[34]), 64'h0);

        // R7 clear slot 13 beyond range
        bus_write(16'h106C, 32'h8000_0000);
        ob_req[13] = 1'b1; settle();
        check("R4 ob line 45", 64'(ivec_o[45]), 64'h1);
        bus_write(16'h186C, 32'h0);
        settle();
        check("R7 slot 13 clear ignored", 64'(ivec_o[45]), 64'h1);

        // R7 unmapped offset
        bus_write(16'h2004, 32'hFFFF_FFFF);
        bus_read(16'h2004, r); check("R7 unmapped read", 64'(r), 64'h0);
        bus_read(16'h0C0C, r); check("R7 map1 unchanged", 64'(r), 64'h8000_07C4);

        // R8 read data holds
        held = r;
        repeat (3) @(negedge clk);
        check("R8 rdata holds", 64'(rdata_o), 64'(held));

        // R1 warm reset
        rst_n = 1'b0; @(negedge clk);
        check("R1 ivec after reset", 64'(ivec_o), 64'h0);
        rst_n = 1'b1; @(negedge clk);
        bus_read(16'h0C0C, r); check("R1 map1 enable cleared", 64'(r), 64'h0000_07C4);
        bus_read(16'h106C, r); check("R1 ob map13 enable cleared", 64'(r), 64'h0000_07ED);

        // Random phase against the model (R4 R5 R6 R7 R8)
        pci_req = '0; ob_req = '0;
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            check("R4 R5 R6 random ivec", 64'(ivec_o), 64'(m_ivec));
            check("R2 R3 R7 R8 random rdata", 64'(rdata_o), 64'(m_rdata));
            case ($urandom_range(0, 5))
                0: addr = 16'h0C04 + 16'(8 * $urandom_range(0, 7));
                1: addr = 16'h1004 + 16'(8 * $urandom_range(0, 15));
                2: addr = 16'h1404 + 16'(8 * $urandom_range(0, 7));
                3: addr = 16'h1804 + 16'(8 * $urandom_range(0, 15));
                4: addr = 16'h0C00 + 16'(8 * $urandom_range(0, 7));
                default: addr = 16'($urandom());
            endcase
            wr_en = ($urandom_range(0, 3) == 0);
            rd_en = ($urandom_range(0, 2) == 0);
            wdata = $urandom();
            pci_req = pci_req ^ ($urandom() & $urandom() & $urandom());
            ob_req  = ob_req ^ 16'($urandom() & $urandom() & $urandom());
        end
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule